// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a local scratchpad of 32-bit words spread over 32 single-ported banks. A word's bank is its word address modulo 32, and its row within that bank is the word address divided by 32. A request carries 32 lanes. Each lane has its own word address and active bit. One read/write flag and one valid strobe cover the whole request.

Once a request is accepted, the block works through it in passes, one pass per clock. In each pass every bank serves exactly one address. That address is the one held by the lowest-numbered lane still pending on that bank. Every pending lane that holds that same address is served in the same pass. Lanes that read one word therefore share one bank access, and lanes that write one word resolve to the highest-numbered of them. Lanes that lose their bank wait for a later pass.

The number of passes is the largest count of distinct active addresses that fall into any single bank. The block reports that count on `passCount` next to the per-lane read data when it raises `done`. Both stay on the outputs until the next request is accepted.

Top module: `spad_banked`

## Requirements
- R1: After reset, `busy` and `done` are 0, `passCount` is 0 and every lane of `rdData` is 0.
- R2: Word address A lives in bank A mod 32 at row A div 32, so its bank is the low 5 address bits. A word written through any lane is returned on a later read of the same address through any lane.
- R3: A request is accepted when `reqValid` is 1 while `busy` is 0, and `busy` is 1 in the following cycle. If all active lanes map to different banks, the request finishes in one pass, with `done` high in the cycle after the first clock edge that follows acceptance.
- R4: A request whose worst bank holds n distinct active addresses takes n passes. `busy` stays high until `done`, and `done` rises in the cycle after the n-th clock edge following the accepting edge, with `passCount` equal to n.
- R5: Active lanes that read the same address get the same word and together count as one address in the pass count. A 32-lane broadcast read therefore takes one pass.
- R6: When several active lanes write the same address in one request, the stored word is the data of the highest-numbered of those lanes.
- R7: Inactive lanes make no bank access and add nothing to the pass count. Their `rdData` lane reads 0. A request with no active lane takes 0 passes and raises `done` one cycle after acceptance.
- R8: `reqValid` while `busy` is 1 is ignored. It changes neither memory, the running request's result nor its pass count.
- R9: A column walk with word stride 32 (lane l at address 32*l) takes 32 passes. With stride 33 (lane l at address 33*l) it takes one pass.
- R10: `done` is a one-cycle pulse and is never high together with `busy`. On a write request all `rdData` lanes read 0. `rdData` and `passCount` hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqWrite | input | 1 | 1 for a write request, 0 for a read request |
| reqActive | input | 32 | Per-lane active bits, bit l for lane l |
| reqAddr | input | 320 | Lane word addresses, lane l in bits [10*l+9:10*l] |
| reqWdata | input | 1024 | Lane write data, lane l in bits [32*l+31:32*l] |
| busy | output | 1 | High while a request is being served |
| done | output | 1 | One-cycle pulse when a request is complete |
| passCount | output | 6 | Number of passes the last request took |
| rdData | output | 1024 | Lane read data, lane l in bits [32*l+31:32*l] |

## Verification
Each result is due a fixed number of cycles after the accepting edge, and that number comes from the request alone. `done`, `passCount` and `rdData` appear in the cycle after the n-th following edge, where n is the worst per-bank count of distinct addresses (at least one edge). The driver counts edges with its own cycle counter, computes n from its lane pattern and records the cycle in which `done` must be seen. The monitor samples on the falling edge and checks that `done` arrives in exactly that cycle, with the expected pass count and the read data from a shadow copy of memory. The ignored-request case is checked by reading back the word a stray write would have hit.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } spadStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new request
    logic doPass;   // perform one bank pass
    logic finish;   // request completes this cycle
  } spadCtrlT;

endpackage

// File: rtl/spad_arbiter.sv
module spad_arbiter #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  localparam int BANK_W = $clog2(BANKS),
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]             pending,
  input  logic [LANES-1:0][ADDR_W-1:0] laneAddr,
  output logic [BANKS-1:0]             selValid,
  output logic [BANKS-1:0][ADDR_W-1:0] selAddr,
  output logic [LANES-1:0]             served,
  output logic [BANKS-1:0][LANE_W-1:0] wrLane
);

  // each bank picks the address of its lowest pending lane
  for (genvar b = 0; b < BANKS; b++) begin : g_pick
    logic              pickValid;
    logic [ADDR_W-1:0] pickAddr;
    always_comb begin
      pickValid = 1'b0;
      pickAddr  = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending[l] && (laneAddr[l][BANK_W-1:0] == BANK_W'(b))) begin
          pickValid = 1'b1;
          pickAddr  = laneAddr[l];
        end
      end
    end
    assign selValid[b] = pickValid;
    assign selAddr[b]  = pickAddr;
  end

  // a lane is served when its bank picked exactly its address
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      served[l] = pending[l]
                  && selValid[laneAddr[l][BANK_W-1:0]]
                  && (selAddr[laneAddr[l][BANK_W-1:0]] == laneAddr[l]);
    end
  end

  // write source per bank: highest served lane on that bank
  for (genvar b = 0; b < BANKS; b++) begin : g_wsel
    logic [LANE_W-1:0] winLane;
    always_comb begin
      winLane = '0;
      for (int l = 0; l < LANES; l++) begin
        if (served[l] && (laneAddr[l][BANK_W-1:0] == BANK_W'(b))) begin
          winLane = LANE_W'(l);
        end
      end
    end
    assign wrLane[b] = winLane;
  end

endmodule

// File: rtl/spad_datapath.sv
module spad_datapath
  import spad_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int LANE_W = $clog2(LANES),
  localparam int ROW_W  = ADDR_W - BANK_W,
  localparam int DEPTH  = 1 << ROW_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  spadCtrlT                     ctrl,
  input  logic                         reqWrite,
  input  logic [LANES-1:0]             reqActive,
  input  logic [LANES-1:0][ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0][DATA_W-1:0] reqWdata,
  output logic                         pendingAny,
  output logic                         lastPass,
  output logic [LANES-1:0][DATA_W-1:0] rdData
);

  logic                         writeQ;
  logic [LANES-1:0]             pendingQ;
  logic [LANES-1:0][ADDR_W-1:0] addrQ;
  logic [LANES-1:0][DATA_W-1:0] wdataQ;
  logic [LANES-1:0][DATA_W-1:0] rdQ;

  logic [BANKS-1:0]             selValid;
  logic [BANKS-1:0][ADDR_W-1:0] selAddr;
  logic [LANES-1:0]             served;
  logic [BANKS-1:0][LANE_W-1:0] wrLane;
  logic [BANKS-1:0][DATA_W-1:0] bankRd;

  spad_arbiter #(
    .LANES (LANES),
    .BANKS (BANKS),
    .ADDR_W(ADDR_W)
  ) arb_i (
    .pending (pendingQ),
    .laneAddr(addrQ),
    .selValid(selValid),
    .selAddr (selAddr),
    .served  (served),
    .wrLane  (wrLane)
  );

  // request state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      writeQ   <= 1'b0;
      pendingQ <= '0;
    end else if (ctrl.capture) begin
      writeQ   <= reqWrite;
      pendingQ <= reqActive;
    end else if (ctrl.doPass) begin
      pendingQ <= pendingQ & ~served;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.capture) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  // storage banks, one port each
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ROW_W-1:0]  row;
    assign row = selAddr[b][ADDR_W-1:BANK_W];
    always_ff @(posedge clk) begin
      if (ctrl.doPass && writeQ && selValid[b]) begin
        mem[row] <= wdataQ[wrLane[b]];
      end
    end
    assign bankRd[b] = mem[row];
  end

  // per-lane read capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdQ <= '0;
    end else if (ctrl.capture) begin
      rdQ <= '0;
    end else if (ctrl.doPass && !writeQ) begin
      for (int l = 0; l < LANES; l++) begin
        if (served[l]) begin
          rdQ[l] <= bankRd[addrQ[l][BANK_W-1:0]];
        end
      end
    end
  end

  assign pendingAny = |pendingQ;
  assign lastPass   = pendingAny && ((pendingQ & ~served) == '0);
  assign rdData     = rdQ;

endmodule

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
#(
  parameter int LANES = 32,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             pendingAny,
  input  logic             lastPass,
  output spadCtrlT         ctrl,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] passCount
);

  spadStateT        stateQ;
  logic             doneQ;
  logic [CNT_W-1:0] cntQ;

  always_comb begin
    ctrl.capture = (stateQ == ST_IDLE) && reqValid;
    ctrl.doPass  = (stateQ == ST_RUN) && pendingAny;
    ctrl.finish  = (stateQ == ST_RUN) && (!pendingAny || lastPass);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
      cntQ   <= '0;
    end else begin
      doneQ <= ctrl.finish;
      if (ctrl.capture) begin
        cntQ <= '0;
      end else if (ctrl.doPass) begin
        cntQ <= cntQ + 1'b1;
      end
      if (ctrl.capture) begin
        stateQ <= ST_RUN;
      end else if (ctrl.finish) begin
        stateQ <= ST_IDLE;
      end
    end
  end

  assign busy      = (stateQ == ST_RUN);
  assign done      = doneQ;
  assign passCount = cntQ;

endmodule

// File: rtl/spad_banked.sv
module spad_banked
  import spad_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [LANES-1:0]        reqActive,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES*DATA_W-1:0] reqWdata,
  output logic                    busy,
  output logic                    done,
  output logic [CNT_W-1:0]        passCount,
  output logic [LANES*DATA_W-1:0] rdData
);

  spadCtrlT                     ctrl;
  logic                         pendingAny;
  logic                         lastPass;
  logic [LANES-1:0][ADDR_W-1:0] addrV;
  logic [LANES-1:0][DATA_W-1:0] wdataV;
  logic [LANES-1:0][DATA_W-1:0] rdV;

  assign addrV  = reqAddr;
  assign wdataV = reqWdata;
  assign rdData = rdV;

  spad_ctrl #(
    .LANES(LANES)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .pendingAny(pendingAny),
    .lastPass  (lastPass),
    .ctrl      (ctrl),
    .busy      (busy),
    .done      (done),
    .passCount (passCount)
  );

  spad_datapath #(
    .LANES (LANES),
    .BANKS (BANKS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .reqWrite  (reqWrite),
    .reqActive (reqActive),
    .reqAddr   (addrV),
    .reqWdata  (wdataV),
    .pendingAny(pendingAny),
    .lastPass  (lastPass),
    .rdData    (rdV)
  );

endmodule

// File: rtl/spad_chk.sv
module spad_chk #(
  parameter int LANES  = 32,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reqValid,
  input logic                    busy,
  input logic                    done,
  input logic [CNT_W-1:0]        passCount,
  input logic [LANES*DATA_W-1:0] rdData
);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reqValid) |=> busy);

  // R4
  pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (passCount == CNT_W'($past(passCount) + 1'b1)));

  // R4
  pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    passCount <= CNT_W'(LANES));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reqValid) |=> ($stable(passCount) && $stable(rdData)));

endmodule

bind spad_banked spad_chk #(
  .LANES (LANES),
  .DATA_W(DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .busy     (busy),
  .done     (done),
  .passCount(passCount),
  .rdData   (rdData)
);

// File: tb/spad_banked_tb.sv
`timescale 1ns/1ps
module spad_banked_tb_top;

  localparam int LANES  = 32;
  localparam int BANKS  = 32;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int WORDS  = 1 << ADDR_W;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    reqValid;
  logic                    reqWrite;
  logic [LANES-1:0]        reqActive;
  logic [LANES*ADDR_W-1:0] reqAddr;
  logic [LANES*DATA_W-1:0] reqWdata;
  logic                    busy;
  logic                    done;
  logic [CNT_W-1:0]        passCount;
  logic [LANES*DATA_W-1:0] rdData;

  always #2.5 clk = ~clk;

  spad_banked #(
    .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqActive(reqActive), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .done(done), .passCount(passCount), .rdData(rdData)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [ADDR_W-1:0] drvAddr [LANES];
  logic [DATA_W-1:0] drvData [LANES];
  logic [LANES-1:0]  drvActive;
  logic [DATA_W-1:0] shadow  [WORDS];

  // scoreboard queues
  logic [LANES*DATA_W-1:0] expRdQ [$];
  int                      expPassQ [$];
  int                      expDueQ [$];
  string                   tagQ [$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expPasses();
    int worst = 0;
    for (int b = 0; b < BANKS; b++) begin
      int cnt = 0;
      for (int i = 0; i < LANES; i++) begin
        if (drvActive[i] && (int'(drvAddr[i]) % BANKS) == b) begin
          bit seen = 0;
          for (int j = 0; j < i; j++)
            if (drvActive[j] && drvAddr[j] == drvAddr[i]) seen = 1;
          if (!seen) cnt++;
        end
      end
      if (cnt > worst) worst = cnt;
    end
    return worst;
  endfunction

  function automatic logic [DATA_W-1:0] pat(input int a);
    return DATA_W'(a * 32'h0100_0193 + 32'h5A5A_0007);
  endfunction

  // driver: computes expectations, drives one request, pushes to scoreboard
  task automatic send(input bit wr, input string tag);
    int n;
    logic [LANES*DATA_W-1:0] exp;
    do @(negedge clk); while (expPassQ.size() != 0 || busy);
    n   = expPasses();
    exp = '0;
    if (wr) begin
      for (int l = 0; l < LANES; l++)
        if (drvActive[l]) shadow[drvAddr[l]] = drvData[l];
    end else begin
      for (int l = 0; l < LANES; l++)
        if (drvActive[l]) exp[l*DATA_W +: DATA_W] = shadow[drvAddr[l]];
    end
    for (int l = 0; l < LANES; l++) begin
      reqAddr[l*ADDR_W +: ADDR_W]  = drvAddr[l];
      reqWdata[l*DATA_W +: DATA_W] = drvData[l];
    end
    reqActive = drvActive;
    reqWrite  = wr;
    reqValid  = 1'b1;
    @(negedge clk);
    reqValid  = 1'b0;
    expRdQ.push_back(exp);
    expPassQ.push_back(n);
    expDueQ.push_back(cyc + ((n == 0) ? 1 : n));
    tagQ.push_back(tag);
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (expPassQ.size() != 0 || busy);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (expPassQ.size() == 0) begin
          check(1'b0, "R10 unexpected done", 1, 0);
        end else begin
          logic [LANES*DATA_W-1:0] er;
          int ep, ed;
          string tg;
          er = expRdQ.pop_front();
          ep = expPassQ.pop_front();
          ed = expDueQ.pop_front();
          tg = tagQ.pop_front();
          check(cyc == ed, {tg, " done cycle"}, cyc, ed);
          check(int'(passCount) == ep, {tg, " passCount"}, passCount, ep);
          begin
            int bad = -1;
            for (int l = LANES - 1; l >= 0; l--)
              if (rdData[l*DATA_W +: DATA_W] !== er[l*DATA_W +: DATA_W]) bad = l;
            if (bad < 0) check(1'b1, tg, 0, 0);
            else check(1'b0, $sformatf("%s rdData lane %0d", tg, bad),
                       rdData[bad*DATA_W +: DATA_W], er[bad*DATA_W +: DATA_W]);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=%0d expected<%0d", cyc, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqActive = '0; reqAddr = '0; reqWdata = '0;
    for (int l = 0; l < LANES; l++) begin drvAddr[l] = '0; drvData[l] = '0; end
    drvActive = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(passCount == '0, "R1 passCount", passCount, 0);
    check(rdData == '0, "R1 rdData", rdData[31:0], 0);

    // R2/R3 fill whole memory, one row per request, one pass each
    for (int k = 0; k < WORDS / LANES; k++) begin
      for (int l = 0; l < LANES; l++) begin
        drvAddr[l] = ADDR_W'(k * LANES + l);
        drvData[l] = pat(k * LANES + l);
      end
      drvActive = '1;
      send(1'b1, "R2 R3 fill");
    end

    // R2/R3 row reads, also lanes rotated against banks
    for (int k = 0; k < 3; k++) begin
      for (int l = 0; l < LANES; l++)
        drvAddr[l] = ADDR_W'((k * 13) * LANES + ((l + k * 7) % LANES));
      drvActive = '1;
      send(1'b0, "R2 R3 row read");
    end

    // R9 column walk stride 32, then stride 33
    for (int l = 0; l < LANES; l++) drvAddr[l] = ADDR_W'(l * 32);
    send(1'b0, "R9 stride32");
    for (int l = 0; l < LANES; l++) drvAddr[l] = ADDR_W'(l * 33);
    send(1'b0, "R9 stride33");

    // R5 broadcast and two merged groups on one bank
    for (int l = 0; l < LANES; l++) drvAddr[l] = ADDR_W'(77);
    send(1'b0, "R5 broadcast");
    for (int l = 0; l < LANES; l++) drvAddr[l] = ADDR_W'((l < 16) ? 5 : 37);
    send(1'b0, "R5 R4 merged pair");

    // R4 four-way conflict
    for (int l = 0; l < LANES; l++) drvAddr[l] = ADDR_W'((l % 4) * 64 + l / 4);
    send(1'b0, "R4 four-way");

    // R4 sixteen-way conflicting write, then read back
    for (int l = 0; l < LANES; l++) begin
      drvAddr[l] = ADDR_W'(l * 16);
      drvData[l] = 32'hBEEF_0000 + l;
    end
    send(1'b1, "R4 sixteen-way write");
    send(1'b0, "R4 R2 sixteen-way read");

    // R6 same-address write, highest active lane 20 wins
    for (int l = 0; l < LANES; l++) begin
      drvAddr[l] = ADDR_W'(100);
      drvData[l] = 32'hC0DE_0000 + l;
    end
    drvActive = 32'h001F_FFFF;
    send(1'b1, "R6 same-address write");
    drvActive = '1;
    send(1'b0, "R6 readback");

    // R7 partial and empty requests
    for (int l = 0; l < LANES; l++) drvAddr[l] = ADDR_W'(l * 33);
    drvActive = 32'h0000_00F0;
    send(1'b0, "R7 partial read");
    drvActive = '0;
    send(1'b0, "R7 no active lane");

    // R8 stray request while busy must be ignored
    for (int l = 0; l < LANES; l++) drvAddr[l] = ADDR_W'(l * 32 + 3);
    drvActive = '1;
    send(1'b0, "R8 long read");
    check(busy == 1'b1, "R4 busy during passes", busy, 1);
    reqWrite = 1'b1;
    reqActive = '1;
    for (int l = 0; l < LANES; l++) begin
      reqAddr[l*ADDR_W +: ADDR_W]  = ADDR_W'(0);
      reqWdata[l*DATA_W +: DATA_W] = 32'hDEAD_DEAD;
    end
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int l = 0; l < LANES; l++) drvAddr[l] = ADDR_W'(0);
    send(1'b0, "R8 stray write absent");

    waitIdle();
    // R10 results hold while idle
    begin
      logic [LANES*DATA_W-1:0] held;
      held = rdData;
      repeat (4) @(negedge clk);
      check(rdData == held, "R10 rdData hold", rdData[31:0], held[31:0]);
      check(passCount == CNT_W'(1), "R10 passCount hold", passCount, 1);
      check(done == 1'b0, "R10 done pulse", done, 0);
    end

    // R10 write request returns zero read data
    for (int l = 0; l < LANES; l++) begin drvAddr[l] = ADDR_W'(l); drvData[l] = pat(l); end
    send(1'b1, "R10 write zero rdData");
    waitIdle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule